// File: doc/BRIEF.md
# Word and Range Recognizer Bank

This block sits between the acquisition front end and the trigger sequencer of a logic analyzer. It compares each valid data sample with a bank of programmable word recognizers. Each recognizer holds a reference value and a don't-care mask. It then hands the sequencer one registered match flag per recognizer. The sample arrives already concatenated with its most significant channel group on top, and any channel groups that are absent are simply left out.

Software can turn some of the bank into full-width range recognizers through a range count register. Each active range takes three word recognizers. Two of them hold the inclusive lower and upper bounds, and the third is held in reserve. The sequencer can reload any reference from the live sample with a strobe and an index, so that a later sample can be compared against data that was seen earlier. The block has no state machine. Its only sequential parts are the configuration registers and the match output registers.

Top module: `wrb_bank`

## Requirements
- R1: After reset, all match outputs are 0, and every reference, mask and the range count are 0. As a result, the first valid sample of value 0 sets every word match bit.
- R2: The configuration write port decodes `wr_addr` as follows:
  - bits [IDX_W+1:IDX_W] select the field: 0 is reference, 1 is mask, 2 is range count, and 3 is ignored.
  - bits [IDX_W-1:0] select the recognizer index.
- R3: Word match bit i is 1 when every sample bit whose mask bit is 0 equals the reference bit. A mask bit of 1 marks a don't-care bit.
- R4: The match outputs are registered. They show the result for a sample one clock edge after that sample is presented with `smp_valid` high.
- R5: While `smp_valid` is low, both match outputs keep their previous values.
- R6: A range count write with a value from 0 to N_RANGE is accepted. A larger value is ignored, and the previous count is kept.
- R7: Range k is active when k is less than the range count. Its lower bound is reference 3k and its upper bound is reference 3k+1. It matches when lower ≤ sample ≤ upper, using an unsigned comparison with both bounds inclusive. An inactive range always outputs 0.
- R8: Word recognizers 0 to 3·count−1 are taken by the active ranges, and their word match bits are forced to 0.
- R9: When `rld_en` is high in a cycle where `smp_valid` is high, that sample is copied into reference `rld_idx`. The comparison for that same sample still uses the old reference, and the new reference takes effect from the next valid sample.
- R10: When `rld_en` is high while `smp_valid` is low, it has no effect.
- R11: If a reload and a reference write target the same recognizer in the same cycle, the reload wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | DATA_W | Acquired sample, most significant group on top |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | IDX_W+2 | Field select and recognizer index |
| wr_data | input | DATA_W | Configuration write value |
| rld_en | input | 1 | Reload strobe from the sequencer |
| rld_idx | input | IDX_W | Recognizer whose reference is reloaded |
| word_match | output | N_WORD | Registered word match flags |
| range_match | output | N_RANGE | Registered range match flags |

## Verification
The bench uses 8-bit samples so that every check can sweep all 256 sample values.

- **Word sweep.** Mixed references and masks are swept over every sample value. This separates masked bits from compared bits, and exposes any off-by-one decode of the mask polarity.
- **Range sweeps.** These run with one, two and four active ranges. The bounds include a single-point range, a range covering the full scale, and an inverted range (lower bound above upper bound). Together they separate the inclusive and exclusive comparisons, signed and unsigned comparison, and the handling of consumed and inactive recognizers.
- **Reload sequences.** Short sequences mix reload strobes with valid and idle cycles and with same-cycle writes. They tell apart old-reference and new-reference comparison, gating by `smp_valid`, and write/reload priority.

// File: rtl/wrb_pkg.sv
package wrb_pkg;
    typedef enum logic [1:0] {
        FLD_REF  = 2'd0,
        FLD_MASK = 2'd1,
        FLD_RCNT = 2'd2,
        FLD_NONE = 2'd3
    } fld_e;
endpackage

// File: rtl/wrb_regs.sv
module wrb_regs
    import wrb_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int N_WORD  = 16,
    parameter int N_RANGE = 4,
    parameter int IDX_W   = 4,
    parameter int CNT_W   = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  fld_e                           wr_fld,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [DATA_W-1:0]              wr_data,
    input  logic                           rld_en,
    input  logic [IDX_W-1:0]               rld_idx,
    input  logic                           smp_valid,
    input  logic [DATA_W-1:0]              smp_data,
    output logic [N_WORD-1:0][DATA_W-1:0]  refs,
    output logic [N_WORD-1:0][DATA_W-1:0]  masks,
    output logic [CNT_W-1:0]               rng_cnt
);
    logic rld_go;
    logic cnt_ok;

    assign rld_go = rld_en && smp_valid;
    assign cnt_ok = (wr_data <= DATA_W'(N_RANGE));

    // Reference and mask storage, one pair per recognizer.
    for (genvar g = 0; g < N_WORD; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                refs[g] <= '0;
            end else if (rld_go && rld_idx == IDX_W'(g)) begin
                refs[g] <= smp_data;
            end else if (wr_en && wr_fld == FLD_REF && wr_idx == IDX_W'(g)) begin
                refs[g] <= wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                masks[g] <= '0;
            end else if (wr_en && wr_fld == FLD_MASK && wr_idx == IDX_W'(g)) begin
                masks[g] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rng_cnt <= '0;
        end else if (wr_en && wr_fld == FLD_RCNT && cnt_ok) begin
            rng_cnt <= wr_data[CNT_W-1:0];
        end
    end

    // R9: a reload in a valid cycle leaves the sample in the chosen reference
    a_r9_reload_copy: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rld_en && smp_valid) |-> refs[$past(rld_idx)] == $past(smp_data));

    // R6: an out-of-range count write leaves the count alone
    a_r6_cnt_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && wr_fld == FLD_RCNT && wr_data > DATA_W'(N_RANGE)) |-> $stable(rng_cnt));

    // R10: a reload while no sample is valid leaves the reference untouched
    a_r10_idle_reload: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rld_en && !smp_valid && !wr_en) |-> $stable(refs));
endmodule

// File: rtl/wrb_word_cmp.sv
module wrb_word_cmp #(
    parameter int DATA_W = 32,
    parameter int N_WORD = 16
) (
    input  logic [N_WORD-1:0][DATA_W-1:0] refs,
    input  logic [N_WORD-1:0][DATA_W-1:0] masks,
    input  logic [DATA_W-1:0]             smp_data,
    output logic [N_WORD-1:0]             hit
);
    for (genvar g = 0; g < N_WORD; g++) begin : g_cmp
        assign hit[g] = ~|((smp_data ^ refs[g]) & ~masks[g]);
    end
endmodule

// File: rtl/wrb_range_cmp.sv
module wrb_range_cmp #(
    parameter int DATA_W  = 32,
    parameter int N_WORD  = 16,
    parameter int N_RANGE = 4,
    parameter int CNT_W   = 3
) (
    input  logic [N_RANGE-1:0][DATA_W-1:0] lo_bnd,
    input  logic [N_RANGE-1:0][DATA_W-1:0] hi_bnd,
    input  logic [CNT_W-1:0]               rng_cnt,
    input  logic [DATA_W-1:0]              smp_data,
    output logic [N_RANGE-1:0]             rng_hit,
    output logic [N_WORD-1:0]              consumed
);
    for (genvar k = 0; k < N_RANGE; k++) begin : g_rng
        assign rng_hit[k] = (rng_cnt > CNT_W'(k)) &&
                            (smp_data >= lo_bnd[k]) && (smp_data <= hi_bnd[k]);
    end

    for (genvar g = 0; g < N_WORD; g++) begin : g_use
        assign consumed[g] = (32'(g) < 32'(rng_cnt) * 32'd3);
    end
endmodule

// File: rtl/wrb_bank.sv
module wrb_bank
    import wrb_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int N_WORD    = 16,
    parameter int N_RANGE   = 4,
    localparam int IDX_W    = $clog2(N_WORD),
    localparam int ADDR_W   = IDX_W + 2,
    localparam int CNT_W    = $clog2(N_RANGE + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [DATA_W-1:0]   smp_data,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                rld_en,
    input  logic [IDX_W-1:0]    rld_idx,
    output logic [N_WORD-1:0]   word_match,
    output logic [N_RANGE-1:0]  range_match
);
    fld_e                           wr_fld;
    logic [IDX_W-1:0]               wr_idx;
    logic [N_WORD-1:0][DATA_W-1:0]  refs;
    logic [N_WORD-1:0][DATA_W-1:0]  masks;
    logic [CNT_W-1:0]               rng_cnt;
    logic [N_RANGE-1:0][DATA_W-1:0] lo_bnd;
    logic [N_RANGE-1:0][DATA_W-1:0] hi_bnd;
    logic [N_WORD-1:0]              word_hit;
    logic [N_WORD-1:0]              consumed;
    logic [N_RANGE-1:0]             rng_hit;

    assign wr_fld = fld_e'(wr_addr[IDX_W+1:IDX_W]);
    assign wr_idx = wr_addr[IDX_W-1:0];

    wrb_regs #(
        .DATA_W(DATA_W), .N_WORD(N_WORD), .N_RANGE(N_RANGE),
        .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_fld(wr_fld), .wr_idx(wr_idx), .wr_data(wr_data),
        .rld_en(rld_en), .rld_idx(rld_idx),
        .smp_valid(smp_valid), .smp_data(smp_data),
        .refs(refs), .masks(masks), .rng_cnt(rng_cnt)
    );

    wrb_word_cmp #(.DATA_W(DATA_W), .N_WORD(N_WORD)) u_word (
        .refs(refs), .masks(masks), .smp_data(smp_data), .hit(word_hit)
    );

    // Range k takes recognizers 3k (low), 3k+1 (high) and 3k+2 (reserve).
    for (genvar k = 0; k < N_RANGE; k++) begin : g_bnd
        assign lo_bnd[k] = refs[3*k];
        assign hi_bnd[k] = refs[3*k+1];
    end

    wrb_range_cmp #(
        .DATA_W(DATA_W), .N_WORD(N_WORD), .N_RANGE(N_RANGE), .CNT_W(CNT_W)
    ) u_range (
        .lo_bnd(lo_bnd), .hi_bnd(hi_bnd), .rng_cnt(rng_cnt),
        .smp_data(smp_data), .rng_hit(rng_hit), .consumed(consumed)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_match  <= '0;
            range_match <= '0;
        end else if (smp_valid) begin
            word_match  <= word_hit & ~consumed;
            range_match <= rng_hit;
        end
    end

    // R5: outputs frozen across idle cycles
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(smp_valid) |-> ($stable(word_match) && $stable(range_match)));

    // R8: recognizers owned by active ranges never report a word match
    a_r8_consumed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(smp_valid) |-> ((word_match & $past(consumed)) == '0));

    // R7: an inactive range never reports a match
    for (genvar k = 0; k < N_RANGE; k++) begin : g_chk
        a_r7_inactive_range: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(smp_valid) && $past(rng_cnt) <= CNT_W'(k)) |-> !range_match[k]);
    end
endmodule

// File: tb/test_wrb_bank.sv
`timescale 1ns/1ps
module test_wrb_bank;
    localparam int DW = 8;
    localparam int NW = 16;
    localparam int NR = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          smp_valid;
    logic [DW-1:0] smp_data;
    logic          wr_en;
    logic [5:0]    wr_addr;
    logic [DW-1:0] wr_data;
    logic          rld_en;
    logic [3:0]    rld_idx;
    logic [NW-1:0] word_match;
    logic [NR-1:0] range_match;

    int total = 0;
    int bad   = 0;

    logic [DW-1:0] bref [NW];
    logic [DW-1:0] bmsk [NW];
    int            bcnt;
    logic [NW-1:0] ew;
    logic [NR-1:0] er;

    always #2.5 clk = ~clk;

    wrb_bank #(.DATA_W(DW), .N_WORD(NW), .N_RANGE(NR)) i_wrb_bank (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rld_en(rld_en), .rld_idx(rld_idx),
        .word_match(word_match), .range_match(range_match)
    );

    function automatic logic [NW-1:0] exp_words(logic [DW-1:0] s);
        logic [NW-1:0] e;
        for (int i = 0; i < NW; i++)
            e[i] = (((s ^ bref[i]) & ~bmsk[i]) == '0) && !(i < 3 * bcnt);
        return e;
    endfunction

    function automatic logic [NR-1:0] exp_ranges(logic [DW-1:0] s);
        logic [NR-1:0] e;
        for (int k = 0; k < NR; k++)
            e[k] = (k < bcnt) && (s >= bref[3*k]) && (s <= bref[3*k+1]);
        return e;
    endfunction

    task automatic check(string req);
        total++;
        if (word_match !== ew || range_match !== er) begin
            bad++;
            $display("FAIL %s: actual words=%h ranges=%h expected words=%h ranges=%h",
                     req, word_match, range_match, ew, er);
        end
    endtask

    // field: 0 ref, 1 mask, 2 range count
    task automatic wr(int fld, int idx, logic [DW-1:0] d);
        wr_en = 1'b1; wr_addr = {2'(fld), 4'(idx)}; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (fld == 0) bref[idx] = d;
        if (fld == 1) bmsk[idx] = d;
        if (fld == 2 && d <= NR) bcnt = d;
    endtask

    task automatic samp(logic v, logic [DW-1:0] d, logic rl, int ri, string req);
        smp_valid = v; smp_data = d; rld_en = rl; rld_idx = 4'(ri);
        if (v) begin
            ew = exp_words(d);
            er = exp_ranges(d);
        end
        @(negedge clk);
        check(req);
        if (rl && v) bref[ri] = d;
        smp_valid = 1'b0; rld_en = 1'b0;
    endtask

    initial begin
        #1000000;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; smp_valid = 1'b0; smp_data = '0; wr_en = 1'b0;
        wr_addr = '0; wr_data = '0; rld_en = 1'b0; rld_idx = '0;
        for (int i = 0; i < NW; i++) begin bref[i] = '0; bmsk[i] = '0; end
        bcnt = 0; ew = '0; er = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset outputs");
        samp(1'b1, 8'h00, 1'b0, 0, "R1 reset contents");
        samp(1'b1, 8'h01, 1'b0, 0, "R1 R4 nonzero sample");

        // R2 R3: mixed references and masks, full sweep
        wr(0, 5, 8'hA5); wr(1, 5, 8'h0F);
        wr(0, 6, 8'h3C);
        wr(0, 9, 8'h80); wr(1, 9, 8'h7F);
        wr(1, 15, 8'hFF);
        for (int s = 0; s < 256; s++) samp(1'b1, 8'(s), 1'b0, 0, "R3 word sweep");

        // R5: idle cycles with changing data keep outputs
        samp(1'b1, 8'hA0, 1'b0, 0, "R4 load");
        samp(1'b0, 8'h3C, 1'b0, 0, "R5 hold a");
        samp(1'b0, 8'h00, 1'b0, 0, "R5 hold b");

        // R6: illegal count ignored, legal accepted
        wr(2, 0, 8'd5);
        samp(1'b1, 8'hA5, 1'b0, 0, "R6 count 5 ignored");
        wr(2, 0, 8'd2);
        wr(2, 0, 8'd200);
        wr(0, 0, 8'h20); wr(0, 1, 8'h40);
        wr(0, 3, 8'h80); wr(0, 4, 8'h80);
        for (int s = 0; s < 256; s++) samp(1'b1, 8'(s), 1'b0, 0, "R7 R8 two ranges");

        // four ranges: full-scale and inverted bounds
        wr(2, 0, 8'd4);
        wr(0, 6, 8'h00); wr(0, 7, 8'hFF);
        wr(0, 9, 8'hF0); wr(0, 10, 8'h10);
        for (int s = 0; s < 256; s++) samp(1'b1, 8'(s), 1'b0, 0, "R7 R8 four ranges");

        wr(2, 0, 8'd1);
        for (int s = 0; s < 256; s += 3) samp(1'b1, 8'(s), 1'b0, 0, "R7 R8 one range");

        // R9: reload compares old reference first
        wr(2, 0, 8'd0);
        wr(0, 12, 8'h00);
        samp(1'b1, 8'h77, 1'b1, 12, "R9 old reference");
        samp(1'b1, 8'h77, 1'b0, 0,  "R9 new reference");

        // R10: reload without valid sample
        wr(0, 13, 8'h01);
        samp(1'b0, 8'h55, 1'b1, 13, "R10 idle reload hold");
        samp(1'b1, 8'h55, 1'b0, 0,  "R10 idle reload ignored");

        // R11: reload beats a same-cycle reference write
        wr_en = 1'b1; wr_addr = {2'd0, 4'd14}; wr_data = 8'h11;
        smp_valid = 1'b1; smp_data = 8'h22; rld_en = 1'b1; rld_idx = 4'd14;
        ew = exp_words(8'h22); er = exp_ranges(8'h22);
        @(negedge clk);
        check("R11 same cycle");
        wr_en = 1'b0; rld_en = 1'b0; smp_valid = 1'b0;
        bref[14] = 8'h22;
        samp(1'b1, 8'h22, 1'b0, 0, "R11 reload wins");
        samp(1'b1, 8'h11, 1'b0, 0, "R11 write lost");

        // R2: field 3 is ignored
        wr(3, 6, 8'hEE);
        samp(1'b1, 8'h3C, 1'b0, 0, "R2 unused field");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule